// File: doc/BRIEF.md
# SCSI Controller Data FIFO

This block is the byte queue that sits between the host register port of a SCSI controller and its data path. A host write to the data register pushes one byte. A host read pops one byte into a registered read-data output. The current fill level is shown on a flags output. Each successful pop raises a one-cycle interrupt request. The queue holds up to fifteen bytes: a write that arrives with fifteen already stored is dropped and reported as an overrun. Whenever the queue drains to empty, both the read and write pointers return to slot zero.

While a staged select sequence is in progress, a command-capture mode sends host writes into a separate command buffer and leaves the data queue untouched. A load port places a two-byte completion response (status byte, then zero) at the head of the queue in one cycle. A chip reset input clears the queue and the capture mode in one cycle. The bus phase input decides what a pop returns. In the data-out phase a pop returns zero and the read pointer does not move.

Top module: `scsi_data_fifo`

## Requirements
- R1: After the synchronous reset, count_o, flags_o, rd_data_o, irq_o, overrun_o, cmd_mode_o and cmd_len_o are all zero.
- R2: Each accepted write raises count_o by one. flags_o always equals count_o zero-extended to 8 bits. With phase_i not 2'b00, pops return the stored bytes in write order on rd_data_o in the cycle after rd_en_i, and each pop lowers count_o by one.
- R3: A data write that arrives while count_o is DEPTH-1 (15) is discarded. overrun_o is high for exactly the next cycle and count_o stays at 15. count_o never exceeds DEPTH-1.
- R4: A pop with count_o nonzero drives irq_o high for exactly the following cycle.
- R5: A pop with count_o nonzero while phase_i is 2'b00 (data-out) returns 0x00 and lowers count_o by one. It does not advance the read pointer, so a later pop in another phase returns the byte that was skipped.
- R6: When count_o reaches zero, both pointers rewind to slot 0. The next byte written is the next byte read, even if earlier data-out pops left the read pointer behind.
- R7: While cmd_mode_o is high, writes go into the command buffer at index cmd_len_o, and cmd_len_o increments up to CMD_DEPTH. Writes beyond CMD_DEPTH are dropped. count_o is unchanged. cmd_rd_data_o shows the buffer entry at cmd_rd_addr_i one cycle later. cmd_start_i sets the mode and clears cmd_len_o. cmd_stop_i clears the mode, and wins if both are asserted.
- R8: A pop with count_o zero leaves rd_data_o at its previous value, leaves count_o at zero, and does not raise irq_o.
- R9: rsp_load_i replaces the queue contents with rsp_status_i followed by 0x00. It sets count_o and flags_o to 2, so the next two pops return the status byte and then 0x00.
- R10: chip_rst_i clears count_o, both pointers, cmd_mode_o and cmd_len_o in the cycle it is sampled. rd_data_o is not affected.
- R11: A write and a read in the same cycle both take effect. With count_o between 1 and 14, count_o is unchanged and the oldest byte is returned. With count_o at 0, only the write is accepted and no interrupt is raised. With count_o at 15, the write is rejected as an overrun while the pop proceeds.
- R12: chip_rst_i takes precedence over rsp_load_i, and rsp_load_i takes precedence over any data write or read in the same cycle; a preempted read leaves rd_data_o and irq_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_rst_i | input | 1 | Chip reset command: clears queue and capture state |
| wr_en_i | input | 1 | Host write strobe for the data register |
| wr_data_i | input | 8 | Byte to write |
| rd_en_i | input | 1 | Host read strobe for the data register |
| rd_data_o | output | 8 | Registered read-data value |
| phase_i | input | 2 | Bus phase field; 2'b00 means data-out |
| cmd_start_i | input | 1 | Enter command-capture mode and clear its length |
| cmd_stop_i | input | 1 | Leave command-capture mode |
| cmd_mode_o | output | 1 | Command-capture mode active |
| cmd_len_o | output | CLW (5) | Bytes captured in the command buffer |
| cmd_rd_addr_i | input | CAW (4) | Command buffer read index |
| cmd_rd_data_o | output | 8 | Command buffer entry, one cycle after the index |
| rsp_load_i | input | 1 | Load the two-byte completion response |
| rsp_status_i | input | 8 | Status byte for the response |
| flags_o | output | 8 | Flags value: fill count, zero-extended |
| count_o | output | CW (5) | Fill count |
| overrun_o | output | 1 | One-cycle pulse: a write was rejected |
| irq_o | output | 1 | One-cycle interrupt request after a successful pop |

## Verification
A push and a pop can arrive in the same cycle, and the outcome depends on the fill level. The bench provokes this with an empty queue, a partly filled queue and a queue at its fifteen-byte limit. In each case it checks the count, the overrun and interrupt pulses, and the byte order of the remaining contents against values computed from the write sequence. The response load and the chip reset can also coincide with host traffic. The bench checks that the discarded write does not show up and that the preempted pop leaves the read data unchanged.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RSP_BYTES = 2;
  typedef logic [BYTE_W-1:0] byte_t;

  // Data-out phase: the phase field is all zero.
  function automatic logic phase_is_out(input logic [1:0] ph);
    return ph == 2'b00;
  endfunction
endpackage

// File: rtl/sfifo_ctrl.sv
`timescale 1ns/1ps
module sfifo_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          load2_i,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  input  logic          hold_rptr_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] count_o,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic          overrun_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH - 1);

  logic          at_limit;
  logic          pop_adv;
  logic [CW-1:0] cnt_nx;
  logic [AW-1:0] wp_nx;
  logic [AW-1:0] rp_nx;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign at_limit  = (count_o == LIMIT);
  assign push_ok_o = wr_req_i && !at_limit;
  assign pop_ok_o  = rd_req_i && (count_o != '0);
  assign pop_adv   = pop_ok_o && !hold_rptr_i;

  always_comb begin
    cnt_nx = count_o;
    if (push_ok_o) cnt_nx = cnt_nx + CW'(1);
    if (pop_ok_o)  cnt_nx = cnt_nx - CW'(1);
    wp_nx = push_ok_o ? bump(wptr_o) : wptr_o;
    rp_nx = pop_adv ? bump(rptr_o) : rptr_o;
    // rewind on drain
    if (cnt_nx == '0) begin
      wp_nx = '0;
      rp_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      count_o   <= '0;
      wptr_o    <= '0;
      rptr_o    <= '0;
      overrun_o <= 1'b0;
      irq_o     <= 1'b0;
    end else if (load2_i) begin
      count_o   <= CW'(sfifo_pkg::RSP_BYTES);
      wptr_o    <= AW'(sfifo_pkg::RSP_BYTES);
      rptr_o    <= '0;
      overrun_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      count_o   <= cnt_nx;
      wptr_o    <= wp_nx;
      rptr_o    <= rp_nx;
      overrun_o <= wr_req_i && at_limit;
      irq_o     <= pop_ok_o;
    end
  end
endmodule

// File: rtl/sfifo_store.sv
`timescale 1ns/1ps
module sfifo_store
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  byte_t         wdata_i,
  input  logic          load2_i,
  input  byte_t         status_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  input  logic          zero_i,
  output byte_t         rdata_o
);
  byte_t [DEPTH-1:0] cells;

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    byte_t q;
    logic  hit;
    assign hit = we_i && (waddr_i == AW'(e));
    if (e == 0) begin : g_status
      always_ff @(posedge clk) begin
        if (load2_i)  q <= status_i;
        else if (hit) q <= wdata_i;
      end
    end else if (e == 1) begin : g_trail
      always_ff @(posedge clk) begin
        if (load2_i)  q <= '0;
        else if (hit) q <= wdata_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (hit) q <= wdata_i;
      end
    end
    assign cells[e] = q;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (re_i) rdata_o <= zero_i ? '0 : cells[raddr_i];
  end
endmodule

// File: rtl/sfifo_cmd.sv
`timescale 1ns/1ps
module sfifo_cmd
  import sfifo_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  localparam int CAW = $clog2(CMD_DEPTH),
  localparam int CLW = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_i,
  input  logic           start_i,
  input  logic           stop_i,
  input  logic           wr_i,
  input  byte_t          wdata_i,
  input  logic [CAW-1:0] raddr_i,
  output logic           mode_o,
  output logic [CLW-1:0] len_o,
  output byte_t          rdata_o
);
  byte_t cbuf_q [CMD_DEPTH];
  logic  room;
  logic  take;

  assign room = len_o < CLW'(CMD_DEPTH);
  assign take = mode_o && wr_i && room && !clr_i;

  always_ff @(posedge clk) begin
    if (take) cbuf_q[len_o[CAW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= cbuf_q[raddr_i];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      mode_o <= 1'b0;
      len_o  <= '0;
    end else begin
      if (stop_i)       mode_o <= 1'b0;
      else if (start_i) mode_o <= 1'b1;
      if (start_i)      len_o <= '0;
      else if (take)    len_o <= len_o + CLW'(1);
    end
  end
endmodule

// File: rtl/scsi_data_fifo.sv
`timescale 1ns/1ps
module scsi_data_fifo
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CMD_DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int CAW = $clog2(CMD_DEPTH),
  localparam int CLW = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           chip_rst_i,
  input  logic           wr_en_i,
  input  logic [7:0]     wr_data_i,
  input  logic           rd_en_i,
  output logic [7:0]     rd_data_o,
  input  logic [1:0]     phase_i,
  input  logic           cmd_start_i,
  input  logic           cmd_stop_i,
  output logic           cmd_mode_o,
  output logic [CLW-1:0] cmd_len_o,
  input  logic [CAW-1:0] cmd_rd_addr_i,
  output logic [7:0]     cmd_rd_data_o,
  input  logic           rsp_load_i,
  input  logic [7:0]     rsp_status_i,
  output logic [7:0]     flags_o,
  output logic [CW-1:0]  count_o,
  output logic           overrun_o,
  output logic           irq_o
);
  logic          xfer_en;
  logic          load_en;
  logic          wr_req;
  logic          rd_req;
  logic          out_phase;
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic          push_ok;
  logic          pop_ok;

  // priority: chip reset, then response load, then host traffic
  assign load_en   = rsp_load_i && !chip_rst_i;
  assign xfer_en   = !chip_rst_i && !rsp_load_i;
  assign wr_req    = wr_en_i && !cmd_mode_o && xfer_en;
  assign rd_req    = rd_en_i && xfer_en;
  assign out_phase = phase_is_out(phase_i);

  sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (chip_rst_i),
    .load2_i     (load_en),
    .wr_req_i    (wr_req),
    .rd_req_i    (rd_req),
    .hold_rptr_i (out_phase),
    .wptr_o      (wptr),
    .rptr_o      (rptr),
    .count_o     (count_o),
    .push_ok_o   (push_ok),
    .pop_ok_o    (pop_ok),
    .overrun_o   (overrun_o),
    .irq_o       (irq_o)
  );

  sfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .we_i     (push_ok),
    .waddr_i  (wptr),
    .wdata_i  (wr_data_i),
    .load2_i  (load_en),
    .status_i (rsp_status_i),
    .re_i     (pop_ok),
    .raddr_i  (rptr),
    .zero_i   (out_phase),
    .rdata_o  (rd_data_o)
  );

  sfifo_cmd #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (chip_rst_i),
    .start_i (cmd_start_i),
    .stop_i  (cmd_stop_i),
    .wr_i    (wr_en_i),
    .wdata_i (wr_data_i),
    .raddr_i (cmd_rd_addr_i),
    .mode_o  (cmd_mode_o),
    .len_o   (cmd_len_o),
    .rdata_o (cmd_rd_data_o)
  );

  assign flags_o = {{(BYTE_W - CW){1'b0}}, count_o};
endmodule

// File: rtl/sfifo_chk.sv
`timescale 1ns/1ps
module sfifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW = 5,
  parameter int CLW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           chip_rst_i,
  input logic           wr_en_i,
  input logic           rd_en_i,
  input logic [1:0]     phase_i,
  input logic           rsp_load_i,
  input logic           cmd_mode_o,
  input logic [CLW-1:0] cmd_len_o,
  input logic [7:0]     rd_data_o,
  input logic [7:0]     flags_o,
  input logic [CW-1:0]  count_o,
  input logic           overrun_o,
  input logic           irq_o
);
  logic quiet;
  assign quiet = !chip_rst_i && !rsp_load_i;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count_o <= CW'(DEPTH - 1));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (quiet && wr_en_i && !cmd_mode_o && !rd_en_i && count_o == CW'(DEPTH - 1))
    |=> (overrun_o && count_o == CW'(DEPTH - 1)));

  assert_irq_after_pop_R4: assert property (@(posedge clk) disable iff (rst)
    (quiet && rd_en_i && count_o != '0) |=> irq_o);

  assert_irq_needs_data_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(count_o) != '0);

  assert_out_phase_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (quiet && rd_en_i && count_o != '0 && phase_i == 2'b00) |=> rd_data_o == 8'h00);

  assert_cmd_keeps_count_R7: assert property (@(posedge clk) disable iff (rst)
    (quiet && cmd_mode_o && wr_en_i && !rd_en_i) |=> $stable(count_o));

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && count_o == '0) |=> ($stable(rd_data_o) && !irq_o));

  assert_rsp_load_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_load_i && !chip_rst_i) |=> (count_o == CW'(2) && flags_o == 8'd2));

  assert_chip_reset_R10: assert property (@(posedge clk) disable iff (rst)
    chip_rst_i |=> (count_o == '0 && !cmd_mode_o && cmd_len_o == '0));

  assert_flags_match_R2: assert property (@(posedge clk) disable iff (rst)
    flags_o == 8'(count_o));
endmodule

bind scsi_data_fifo sfifo_chk #(.DEPTH(DEPTH), .CW(CW), .CLW(CLW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chip_rst_i (chip_rst_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .phase_i    (phase_i),
  .rsp_load_i (rsp_load_i),
  .cmd_mode_o (cmd_mode_o),
  .cmd_len_o  (cmd_len_o),
  .rd_data_o  (rd_data_o),
  .flags_o    (flags_o),
  .count_o    (count_o),
  .overrun_o  (overrun_o),
  .irq_o      (irq_o)
);

// File: tb/scsi_data_fifo_bench.sv
`timescale 1ns/1ps
module scsi_data_fifo_bench;
  localparam int DEPTH = 16;
  localparam int CMD_DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int CAW = $clog2(CMD_DEPTH);
  localparam int CLW = $clog2(CMD_DEPTH + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst, chip_rst, wr_en, rd_en, cmd_start, cmd_stop, rsp_load;
  logic [7:0]     wr_data, rsp_status, rd_data, cmd_rd_data, flags;
  logic [1:0]     phase;
  logic [CAW-1:0] cmd_addr;
  logic           cmd_mode, overrun, irq;
  logic [CLW-1:0] cmd_len;
  logic [CW-1:0]  count;

  scsi_data_fifo #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_scsi_data_fifo (
    .clk(clk), .rst(rst), .chip_rst_i(chip_rst),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .phase_i(phase), .cmd_start_i(cmd_start), .cmd_stop_i(cmd_stop),
    .cmd_mode_o(cmd_mode), .cmd_len_o(cmd_len), .cmd_rd_addr_i(cmd_addr),
    .cmd_rd_data_o(cmd_rd_data), .rsp_load_i(rsp_load), .rsp_status_i(rsp_status),
    .flags_o(flags), .count_o(count), .overrun_o(overrun), .irq_o(irq)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic push_pop(input logic [7:0] b);
    wr_en = 1'b1; rd_en = 1'b1; wr_data = b;
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] last;
    rst = 1'b1; chip_rst = 0; wr_en = 0; rd_en = 0; cmd_start = 0; cmd_stop = 0;
    rsp_load = 0; wr_data = 0; rsp_status = 0; phase = 2'b01; cmd_addr = '0;
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1", "count", count, 0);
    chk("R1", "flags", flags, 0);
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "cmd_mode", cmd_mode, 0);
    chk("R1", "cmd_len", cmd_len, 0);

    // R2 / R4 sweep of every fill level
    phase = 2'b01;
    for (int n = 1; n <= DEPTH - 1; n++) begin
      for (int i = 0; i < n; i++) begin
        push(8'(n * 16 + i));
        chk("R2", "count after push", count, i + 1);
      end
      chk("R2", "flags", flags, n);
      for (int i = 0; i < n; i++) begin
        pop();
        chk("R2", "pop data", rd_data, (n * 16 + i) & 255);
        chk("R4", "irq pulse", irq, 1);
        chk("R2", "count after pop", count, n - 1 - i);
      end
      tick();
      chk("R4", "irq one cycle", irq, 0);
    end

    // R3 overrun at the limit
    for (int i = 0; i < DEPTH - 1; i++) push(8'(8'h20 + i));
    chk("R3", "count full", count, DEPTH - 1);
    push(8'hEE);
    chk("R3", "overrun pulse", overrun, 1);
    chk("R3", "count held", count, DEPTH - 1);
    tick();
    chk("R3", "overrun one cycle", overrun, 0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      pop();
      chk("R3", "no rejected byte", rd_data, 8'h20 + i);
    end
    chk("R3", "drained", count, 0);

    // R8 pop on empty
    last = rd_data;
    pop();
    chk("R8", "rd_data held", rd_data, last);
    chk("R8", "no irq", irq, 0);
    chk("R8", "count zero", count, 0);

    // R5 data-out pop
    push(8'hAA); push(8'hBB);
    phase = 2'b00;
    pop();
    chk("R5", "zero data", rd_data, 8'h00);
    chk("R5", "count", count, 1);
    chk("R4", "irq in data-out", irq, 1);
    phase = 2'b11;
    pop();
    chk("R5", "skipped byte", rd_data, 8'hAA);
    chk("R5", "empty", count, 0);

    // R6 rewind after data-out drain
    push(8'h11); push(8'h22);
    phase = 2'b00;
    pop(); pop();
    chk("R6", "count zero", count, 0);
    phase = 2'b10;
    push(8'h33);
    pop();
    chk("R6", "rewound read", rd_data, 8'h33);

    // R7 command capture
    cmd_start = 1'b1; tick(); cmd_start = 1'b0;
    chk("R7", "mode on", cmd_mode, 1);
    for (int i = 0; i < 5; i++) push(8'(8'hC0 + i));
    chk("R7", "len", cmd_len, 5);
    chk("R7", "data count unchanged", count, 0);
    for (int i = 0; i < 13; i++) push(8'(8'hD0 + i));
    chk("R7", "len saturates", cmd_len, CMD_DEPTH);
    for (int a = 0; a < CMD_DEPTH; a++) begin
      cmd_addr = CAW'(a);
      tick();
      chk("R7", "cmd byte", cmd_rd_data, (a < 5) ? 8'hC0 + a : 8'hD0 + a - 5);
    end
    cmd_start = 1'b1; cmd_stop = 1'b1; tick(); cmd_start = 1'b0; cmd_stop = 1'b0;
    chk("R7", "stop wins", cmd_mode, 0);
    push(8'h77);
    chk("R7", "data path again", count, 1);
    pop();
    chk("R7", "data byte", rd_data, 8'h77);

    // R9 response load
    push(8'h01); push(8'h02); push(8'h03);
    rsp_status = 8'h5A; rsp_load = 1'b1; tick(); rsp_load = 1'b0;
    chk("R9", "count", count, 2);
    chk("R9", "flags", flags, 2);
    pop(); chk("R9", "status byte", rd_data, 8'h5A);
    pop(); chk("R9", "trailing zero", rd_data, 8'h00);
    chk("R9", "empty", count, 0);

    // R10 chip reset
    push(8'h91); push(8'h92);
    cmd_start = 1'b1; tick(); cmd_start = 1'b0;
    push(8'h93);
    chk("R10", "captured", cmd_len, 1);
    last = rd_data;
    chip_rst = 1'b1; tick(); chip_rst = 1'b0;
    chk("R10", "count", count, 0);
    chk("R10", "mode", cmd_mode, 0);
    chk("R10", "cmd_len", cmd_len, 0);
    chk("R10", "rd_data kept", rd_data, last);
    push(8'h44); pop();
    chk("R10", "fresh data", rd_data, 8'h44);

    // R11 simultaneous push and pop
    push(8'h51); push(8'h52); push(8'h53);
    push_pop(8'h54);
    chk("R11", "mid pop data", rd_data, 8'h51);
    chk("R11", "mid count", count, 3);
    for (int i = 0; i < 3; i++) begin
      pop();
      chk("R11", "mid order", rd_data, 8'h52 + i);
    end
    push_pop(8'h69);
    chk("R11", "empty count", count, 1);
    chk("R11", "empty irq", irq, 0);
    chk("R11", "empty rd_data", rd_data, 8'h54);
    pop();
    chk("R11", "empty write kept", rd_data, 8'h69);
    for (int i = 0; i < DEPTH - 1; i++) push(8'(8'h40 + i));
    push_pop(8'hFF);
    chk("R11", "full overrun", overrun, 1);
    chk("R11", "full count", count, DEPTH - 2);
    chk("R11", "full pop data", rd_data, 8'h40);
    chk("R11", "full irq", irq, 1);
    for (int i = 1; i < DEPTH - 1; i++) begin
      pop();
      chk("R11", "full order", rd_data, 8'h40 + i);
    end
    chk("R11", "full drained", count, 0);

    // R12 priority
    push(8'h61); push(8'h62);
    last = rd_data;
    rsp_status = 8'hA5; rsp_load = 1'b1; wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h6F;
    tick();
    rsp_load = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    chk("R12", "count", count, 2);
    chk("R12", "rd_data held", rd_data, last);
    chk("R12", "no irq", irq, 0);
    pop(); chk("R12", "status first", rd_data, 8'hA5);
    pop(); chk("R12", "zero second", rd_data, 8'h00);
    chk("R12", "write dropped", count, 0);
    push(8'h71);
    chip_rst = 1'b1; rsp_load = 1'b1; tick(); chip_rst = 1'b0; rsp_load = 1'b0;
    chk("R12", "reset beats load", count, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule